// File: doc/BRIEF.md
# Write Status Bit Generator

This block forms the word a flash bank returns on a read while a program or erase is under way, or while an erase is suspended. The command decoder gives it a start pulse and a busy level for the internal operation, the operation kind, the most significant bit of the word being programmed, the suspend state with the address and size of the halted region, and a read strobe with the read address. On each strobe the block registers either a status word or the array word it is given. The status word tells software when the write has finished.

While the operation runs, bit 7 is a polling bit and bit 6 flips on every read. Once busy drops, bit 7 reads the true stored value again and the flipping stops. While an erase is suspended, reads that fall inside the halted sector or block return a marker: bit 6 fixed at 1 and bit 2 flipping. Reads anywhere else return array data. The status bit positions (7, 6, 2) are fixed because host software decodes them. All other status bits read 0.

Top module: `wsb_status_gen`

## Requirements
- R1: After reset `rdData` is all zeros. Both toggle states start at 0, so the first busy read returns bit 6 = 0.
- R2: A read while `opBusy` is high during a program returns bit 7 = inverse of `progPollBit` as sampled at the start pulse. Bit 6 is the toggle state. Every other bit is 0.
- R3: A read while `opBusy` is high during an erase returns bit 7 = 0, bit 6 = the toggle state and every other bit 0.
- R4: Bit 6 inverts after each busy read, so successive busy reads return 0, 1, 0, 1 … counted from the last start pulse.
- R5: In a cycle without `rdStrobe`, `rdData` keeps its value and neither toggle state advances.
- R6: A read with `opBusy` low that is not inside a suspended region returns `arrayData` unchanged.
- R7: With `eraseSusp` high and `opBusy` low, a read inside the suspended region returns bit 6 = 1, bit 2 = the suspend toggle state, and 0 elsewhere. The suspend toggle then inverts.
- R8: While suspended, a read outside the region returns `arrayData` and does not advance the suspend toggle.
- R9: The region is a 2^SEC_LSB-word sector when `suspIsBlock` = 0 and a 2^BLK_LSB-word block when it is 1. It is matched on the address bits at and above that size.
- R10: A start pulse clears both toggle states, so the next busy read and the next suspended-region read both return a toggle value of 0.
- R11: When `opBusy` and `eraseSusp` are both high, a read returns the busy status word, whatever its address.
- R12: The polling bit is captured at the start pulse, and later changes of `progPollBit` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | One-cycle pulse: the internal program or erase begins |
| opBusy | input | 1 | Internal operation in progress |
| opIsErase | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| progPollBit | input | 1 | Bit 7 of the word being programmed |
| eraseSusp | input | 1 | An erase is suspended |
| suspAddr | input | ADDR_W | Any address inside the suspended region |
| suspIsBlock | input | 1 | Suspended region size: 1 block, 0 sector |
| rdStrobe | input | 1 | One read access this cycle |
| rdAddr | input | ADDR_W | Read address |
| arrayData | input | DATA_W | Word read from the array for `rdAddr` |
| rdData | output | DATA_W | Registered read result, valid the cycle after `rdStrobe` |

## Verification
The assertions assume that the decoder never raises `rdStrobe` in the same cycle as `opStart`. They also assume that it changes `suspAddr` and `suspIsBlock` only while no suspend is active. The stimulus holds to both rules. Reads are issued only in cycles without a start pulse, and a new suspended region is chosen only when the suspend state turns on. Within those rules the random sequence mixes starts of both kinds, including programs begun during a suspend, busy drops, suspend entry and exit, idle cycles, and reads inside and outside the halted region. Directed reads sit on the sector and block boundaries.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Status bit positions decoded by host software
  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int SUSP_POS = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeBusy;   // register the busy status word
    logic takeSusp;   // register the suspended-region marker
    logic takeArray;  // register the array word
    logic clearTog;   // reset both toggle states
    logic capture;    // latch the polling bit for the new operation
  } wsbStrobe_t;

endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic              opStart,
  input  logic              opBusy,
  input  logic              eraseSusp,
  input  logic [ADDR_W-1:0] suspAddr,
  input  logic              suspIsBlock,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output wsbStrobe_t        strobes
);

  localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SEC_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_LSB;

  logic [ADDR_W-1:0] regionMask;
  logic              inRegion;
  logic              readOk;

  always_comb begin
    regionMask = suspIsBlock ? BLK_MASK : SEC_MASK;
    inRegion   = (rdAddr & regionMask) == (suspAddr & regionMask);
    // a read that coincides with a start pulse is dropped
    readOk     = rdStrobe && !opStart;

    strobes.capture   = opStart;
    strobes.clearTog  = opStart;
    strobes.takeBusy  = readOk && opBusy;
    strobes.takeSusp  = readOk && !opBusy && eraseSusp && inRegion;
    strobes.takeArray = readOk && !opBusy && !(eraseSusp && inRegion);
  end

endmodule

// File: rtl/wsb_dpath.sv
module wsb_dpath
  import wsb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wsbStrobe_t        strobes,
  input  logic              opIsErase,
  input  logic              progPollBit,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  logic pollQ;
  logic tog6Q;
  logic tog2Q;
  logic [DATA_W-1:0] busyWord;
  logic [DATA_W-1:0] suspWord;

  always_comb begin
    busyWord           = '0;
    busyWord[POLL_POS] = pollQ;
    busyWord[TOG_POS]  = tog6Q;
    suspWord           = '0;
    suspWord[TOG_POS]  = 1'b1;
    suspWord[SUSP_POS] = tog2Q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollQ  <= 1'b0;
      tog6Q  <= 1'b0;
      tog2Q  <= 1'b0;
      rdData <= '0;
    end else begin
      if (strobes.capture) pollQ <= opIsErase ? 1'b0 : ~progPollBit;
      if (strobes.clearTog) begin
        tog6Q <= 1'b0;
        tog2Q <= 1'b0;
      end else begin
        if (strobes.takeBusy) tog6Q <= ~tog6Q;
        if (strobes.takeSusp) tog2Q <= ~tog2Q;
      end
      if (strobes.takeBusy)       rdData <= busyWord;
      else if (strobes.takeSusp)  rdData <= suspWord;
      else if (strobes.takeArray) rdData <= arrayData;
    end
  end

  // R4
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeBusy && !strobes.clearTog) |=> (tog6Q == !$past(tog6Q)));

  // R10
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearTog |=> (!tog6Q && !tog2Q));

  // R7
  susp_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeSusp |=> (rdData[TOG_POS] && !rdData[POLL_POS]));

  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeBusy && !pollQ) |=> !rdData[POLL_POS]);

  // R6
  array_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeArray |=> (rdData == $past(arrayData)));

endmodule

// File: rtl/wsb_status_gen.sv
module wsb_status_gen
  import wsb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 20,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic              opBusy,
  input  logic              opIsErase,
  input  logic              progPollBit,
  input  logic              eraseSusp,
  input  logic [ADDR_W-1:0] suspAddr,
  input  logic              suspIsBlock,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  wsbStrobe_t strobes;

  wsb_ctrl #(
    .ADDR_W (ADDR_W),
    .SEC_LSB(SEC_LSB),
    .BLK_LSB(BLK_LSB)
  ) u_ctrl (
    .opStart    (opStart),
    .opBusy     (opBusy),
    .eraseSusp  (eraseSusp),
    .suspAddr   (suspAddr),
    .suspIsBlock(suspIsBlock),
    .rdStrobe   (rdStrobe),
    .rdAddr     (rdAddr),
    .strobes    (strobes)
  );

  wsb_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opIsErase  (opIsErase),
    .progPollBit(progPollBit),
    .arrayData  (arrayData),
    .rdData     (rdData)
  );

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  // R11
  busy_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !opStart && opBusy && eraseSusp) |=> !(rdData[TOG_POS] && rdData[SUSP_POS]));

endmodule

// File: tb/tb_wsb_status_gen.sv
`timescale 1ns/1ps
module tb_wsb_status_gen;

  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 20;
  localparam int SEC_LSB = 11;
  localparam int BLK_LSB = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opStart = 1'b0;
  logic              opBusy = 1'b0;
  logic              opIsErase = 1'b0;
  logic              progPollBit = 1'b0;
  logic              eraseSusp = 1'b0;
  logic [ADDR_W-1:0] suspAddr = '0;
  logic              suspIsBlock = 1'b0;
  logic              rdStrobe = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] arrayData = '0;
  logic [DATA_W-1:0] rdData;

  always #4 clk = ~clk;

  wsb_status_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)
  ) dut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opBusy(opBusy),
    .opIsErase(opIsErase), .progPollBit(progPollBit), .eraseSusp(eraseSusp),
    .suspAddr(suspAddr), .suspIsBlock(suspIsBlock), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .arrayData(arrayData), .rdData(rdData)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  // reference model state
  logic mPoll = 1'b0, mTog6 = 1'b0, mTog2 = 1'b0, mBusy = 1'b0, mSusp = 1'b0;
  logic mErase = 1'b0;

  function automatic logic inReg(logic [ADDR_W-1:0] a);
    int lsb = suspIsBlock ? BLK_LSB : SEC_LSB;
    return (a >> lsb) == (suspAddr >> lsb);
  endfunction

  function automatic logic [DATA_W-1:0] expWord(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] arr);
    logic [DATA_W-1:0] w = '0;
    if (mBusy) begin
      w[7] = mPoll; w[6] = mTog6;
    end else if (mSusp && inReg(a)) begin
      w[6] = 1'b1; w[2] = mTog2;
    end else begin
      w = arr;
    end
    return w;
  endfunction

  task automatic check(logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: rdData=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] arr, string tag);
    logic [DATA_W-1:0] e;
    rdStrobe = 1'b1; rdAddr = a; arrayData = arr;
    e = expWord(a, arr);
    if (mBusy) mTog6 = ~mTog6;
    else if (mSusp && inReg(a)) mTog2 = ~mTog2;
    @(negedge clk);
    rdStrobe = 1'b0;
    check(rdData, e, tag);
  endtask

  task automatic startOp(logic er, logic pb);
    opStart = 1'b1; opBusy = 1'b1; opIsErase = er; progPollBit = pb;
    mTog6 = 1'b0; mTog2 = 1'b0; mPoll = er ? 1'b0 : ~pb; mBusy = 1'b1; mErase = er;
    @(negedge clk);
    opStart = 1'b0;
  endtask

  task automatic endOp();
    opBusy = 1'b0; mBusy = 1'b0;
    @(negedge clk);
  endtask

  function automatic string autoTag(logic [ADDR_W-1:0] a);
    if (mBusy && mSusp) return "R11";
    if (mBusy) return mErase ? "R3" : "R2";
    if (mSusp && inReg(a)) return "R7";
    if (mSusp) return "R8";
    return "R6";
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] hold;
    int unused;
    unused = $urandom(32'd715);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData, '0, "R1 reset value");

    // program with bit7 = 1 -> poll reads 0
    startOp(1'b0, 1'b1);
    doRead(20'h00123, 16'hFFFF, "R1 first toggle 0 / R2");
    doRead(20'h00456, 16'hFFFF, "R4 second read toggles");
    progPollBit = 1'b0;
    doRead(20'h00456, 16'hFFFF, "R12 poll held after input change");
    hold = rdData;
    repeat (3) @(negedge clk);
    check(rdData, hold, "R5 idle holds data");
    doRead(20'h00001, 16'h0000, "R5 toggle did not advance while idle");
    // erase start clears toggles
    startOp(1'b1, 1'b1);
    doRead(20'h00001, 16'hABCD, "R10 toggle cleared / R3");
    doRead(20'h00001, 16'hABCD, "R3 erase poll 0 / R4");
    endOp();
    doRead(20'h00777, 16'h5A5A, "R6 array after done");

    // suspend in sector mode at 0x0A800 (sector 0x0A800..0x0AFFF)
    suspAddr = 20'h0A9C3; suspIsBlock = 1'b0; eraseSusp = 1'b1; mSusp = 1'b1;
    @(negedge clk);
    doRead(20'h0AFFF, 16'h1111, "R9 last word of sector / R7");
    doRead(20'h0B000, 16'h2222, "R9 first word of next sector / R8");
    doRead(20'h0A800, 16'h3333, "R7 suspend toggle advanced");
    doRead(20'h0F000, 16'h4444, "R8 outside read");
    doRead(20'h0A800, 16'h3333, "R8 toggle not moved by outside read");
    startOp(1'b0, 1'b0);
    doRead(20'h0A800, 16'h3333, "R11 busy over suspend");
    endOp();
    doRead(20'h0A800, 16'h3333, "R10 suspend toggle cleared");
    eraseSusp = 1'b0; mSusp = 1'b0;
    @(negedge clk);
    // block mode: block 0x08000..0x0FFFF
    suspAddr = 20'h0A9C3; suspIsBlock = 1'b1; eraseSusp = 1'b1; mSusp = 1'b1;
    @(negedge clk);
    doRead(20'h0B000, 16'h2222, "R9 same block other sector");
    doRead(20'h08000, 16'h2222, "R9 first word of block");
    doRead(20'h10000, 16'h6666, "R9 first word of next block");
    eraseSusp = 1'b0; mSusp = 1'b0;
    @(negedge clk);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      if (r == 0 && !mBusy) begin
        startOp(mSusp ? 1'b0 : 1'($urandom % 2), 1'($urandom % 2));
      end else if (r <= 2 && mBusy) begin
        endOp();
      end else if (r == 3 && !mBusy) begin
        if (!mSusp) begin
          suspAddr = ADDR_W'($urandom); suspIsBlock = 1'($urandom % 2);
          eraseSusp = 1'b1; mSusp = 1'b1;
        end else begin
          eraseSusp = 1'b0; mSusp = 1'b0;
        end
        @(negedge clk);
      end else if (r == 4) begin
        hold = rdData;
        progPollBit = 1'($urandom % 2);
        @(negedge clk);
        check(rdData, hold, "R5 random idle");
      end else begin
        logic [ADDR_W-1:0] a;
        if (mSusp && ($urandom % 2 == 1))
          a = suspAddr ^ ADDR_W'($urandom % (1 << SEC_LSB));
        else
          a = ADDR_W'($urandom);
        progPollBit = 1'($urandom % 2);
        doRead(a, DATA_W'($urandom), autoTag(a));
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule